// File: doc/BRIEF.md
# Iterative Integer Multiply Unit with High-Half Selection

This block multiplies two XLEN-bit register operands and returns one XLEN-bit result. The result is either the low half of the product or the high half, and the high half can treat the operands as signed by signed, signed by unsigned, or unsigned by unsigned. A word mode works on the low 32 bits of each operand and returns a sign-extended 32-bit answer. Word mode is available only when XLEN is 64.

A request is presented with `valid_i` while the unit is idle. The unit forms an unsigned product with a radix-2 shift-and-add loop that takes one step per bit. Signed treatment comes from a correction applied to the unsigned high half after the loop. Word forms come from extending the operands before the loop. The unit handles one operation at a time, and `done_o` pulses when the result register has been written.

Top module: `mul_unit`

## Requirements
- R1: With `op_i`=0 (low) and `word_i`=0, the result is bits XLEN-1:0 of the product. This holds whatever the operand signs are.
- R2: With `op_i`=1 and `word_i`=0, the result is bits 2*XLEN-1:XLEN of the product of both operands read as two's complement.
- R3: With `op_i`=3 and `word_i`=0, the result is bits 2*XLEN-1:XLEN of the product of both operands read as unsigned.
- R4: With `op_i`=2 and `word_i`=0, the first operand is read as signed and the second as unsigned. The result is the unsigned high half minus the second operand when the first operand is negative, and the unsigned high half otherwise.
- R5: With `word_i`=1 and `op_i`=0, the result is bits 31:0 of the product, sign-extended to 64 bits.
- R6: With `word_i`=1 and a high-half op, the low 32 bits of each operand are extended before multiplying, and the result is bits 63:32 of that product, sign-extended to 64 bits. For op 1 both operands are sign-extended. For op 2 the first is sign-extended and the second zero-extended. For op 3 both are zero-extended.
- R7: When XLEN is not 64, a request with `word_i`=1 is not accepted. `illegal_o` pulses for one cycle in the cycle after the request, `busy_o` stays low and no `done_o` follows.
- R8: `busy_o` is high from the cycle after acceptance through the cycle in which `done_o` is high. A `valid_i` seen while `busy_o` is high is ignored.
- R9: `done_o` is high for exactly one cycle. It starts XLEN+1 clock edges after the accepting edge.
- R10: `result_o` keeps its value from one completion until the next completion.
- R11: After reset, `busy_o`, `done_o` and `illegal_o` are low and `result_o` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Request strobe |
| op_i | input | 2 | 0 = low, 1 = high signed×signed, 2 = high signed×unsigned, 3 = high unsigned×unsigned |
| word_i | input | 1 | 32-bit word mode |
| a_i | input | XLEN | First operand |
| b_i | input | XLEN | Second operand |
| busy_o | output | 1 | An operation is in flight |
| done_o | output | 1 | One-cycle completion pulse |
| illegal_o | output | 1 | A word request was rejected |
| result_o | output | XLEN | Result register |

## Verification
The bench drives the most negative value, -1, zero and one into every op in both modes. These values catch a missing or doubled sign correction: such a design returns a high half that is off by one operand, and it shows most clearly for min×-1 and -1×-1. Word-mode cases put garbage in the upper operand bits and a set bit 31. A wrong extension choice would then leak the upper bits into the product or return an unextended 32-bit value. Each operation also sends a stray request while the unit is busy and checks the exact completion cycle. A unit that restarted on that request, or that counted one step too few or too many, gives a wrong result or a `done_o` at the wrong time.

// File: rtl/mul_pkg.sv
package mul_pkg;
  typedef enum logic [1:0] {
    MUL_LO  = 2'd0,
    MUL_HSS = 2'd1,
    MUL_HSU = 2'd2,
    MUL_HUU = 2'd3
  } mul_op_e;
endpackage

// File: rtl/mul_operand_prep.sv
module mul_operand_prep #(
  parameter int XLEN = 64
) (
  input  logic [1:0]      op_i,
  input  logic            word_i,
  input  logic [XLEN-1:0] a_i,
  input  logic [XLEN-1:0] b_i,
  output logic [XLEN-1:0] a_ext_o,
  output logic [XLEN-1:0] b_ext_o
);
  import mul_pkg::*;
  localparam int HALF = XLEN / 2;

  logic a_sx, b_sx;
  assign a_sx = (op_i != MUL_HUU);
  assign b_sx = (op_i == MUL_HSS) || (op_i == MUL_LO);

  always_comb begin
    if (word_i) begin
      a_ext_o = {{HALF{a_sx & a_i[HALF-1]}}, a_i[HALF-1:0]};
      b_ext_o = {{HALF{b_sx & b_i[HALF-1]}}, b_i[HALF-1:0]};
    end else begin
      a_ext_o = a_i;
      b_ext_o = b_i;
    end
  end
endmodule

// File: rtl/mul_iter_core.sv
module mul_iter_core #(
  parameter int XLEN = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [XLEN-1:0]   a_i,
  input  logic [XLEN-1:0]   b_i,
  output logic              fin_o,
  output logic [2*XLEN-1:0] prod_o
);
  localparam int CW = $clog2(XLEN + 1);

  logic [XLEN-1:0] mcand_q, hi_q, lo_q;
  logic [CW-1:0]   cnt_q;
  logic            run_q, fin_q;
  logic [XLEN:0]   sum;

  assign sum = {1'b0, hi_q} + (lo_q[0] ? {1'b0, mcand_q} : '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mcand_q <= '0;
      hi_q    <= '0;
      lo_q    <= '0;
      cnt_q   <= '0;
      run_q   <= 1'b0;
      fin_q   <= 1'b0;
    end else begin
      fin_q <= 1'b0;
      if (start_i) begin
        mcand_q <= a_i;
        lo_q    <= b_i;
        hi_q    <= '0;
        cnt_q   <= CW'(XLEN);
        run_q   <= 1'b1;
      end else if (run_q) begin
        hi_q  <= sum[XLEN:1];
        lo_q  <= {sum[0], lo_q[XLEN-1:1]};
        cnt_q <= cnt_q - 1'b1;
        if (cnt_q == CW'(1)) begin
          run_q <= 1'b0;
          fin_q <= 1'b1;
        end
      end
    end
  end

  assign fin_o  = fin_q;
  assign prod_o = {hi_q, lo_q};

  a_r9_cnt_live: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q |-> (cnt_q != '0 && cnt_q <= CW'(XLEN)));
  a_r9_fin_after_run: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fin_q |-> !run_q);
endmodule

// File: rtl/mul_result_fix.sv
module mul_result_fix #(
  parameter int XLEN = 64
) (
  input  logic [1:0]        op_i,
  input  logic              word_i,
  input  logic [XLEN-1:0]   a_i,
  input  logic [XLEN-1:0]   b_i,
  input  logic [2*XLEN-1:0] prod_i,
  output logic [XLEN-1:0]   res_o
);
  import mul_pkg::*;
  localparam int HALF = XLEN / 2;

  logic [XLEN-1:0] hi_u, corr_a, corr_b, hi_fix;

  assign hi_u   = prod_i[2*XLEN-1:XLEN];
  // unsigned high half minus the weight each negative signed operand added
  assign corr_a = ((op_i == MUL_HSS || op_i == MUL_HSU) && a_i[XLEN-1]) ? b_i : '0;
  assign corr_b = ((op_i == MUL_HSS) && b_i[XLEN-1]) ? a_i : '0;
  assign hi_fix = hi_u - corr_a - corr_b;

  always_comb begin
    if (word_i) begin
      if (op_i == MUL_LO) res_o = {{HALF{prod_i[HALF-1]}}, prod_i[HALF-1:0]};
      else                res_o = {{HALF{prod_i[XLEN-1]}}, prod_i[XLEN-1:HALF]};
    end else begin
      if (op_i == MUL_LO) res_o = prod_i[XLEN-1:0];
      else                res_o = hi_fix;
    end
  end
endmodule

// File: rtl/mul_unit.sv
module mul_unit #(
  parameter int XLEN = 64
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            valid_i,
  input  logic [1:0]      op_i,
  input  logic            word_i,
  input  logic [XLEN-1:0] a_i,
  input  logic [XLEN-1:0] b_i,
  output logic            busy_o,
  output logic            done_o,
  output logic            illegal_o,
  output logic [XLEN-1:0] result_o
);
  localparam int  HALF    = XLEN / 2;
  localparam bit  WORD_OK = (XLEN == 64);

  logic              busy_q, done_q, illegal_q, word_q;
  logic [1:0]        op_q;
  logic [XLEN-1:0]   a_q, b_q, res_q, a_ext, b_ext, res_d;
  logic              req, bad, accept, fin;
  logic [2*XLEN-1:0] prod;

  assign req    = valid_i && !busy_q;
  assign bad    = word_i && !WORD_OK;
  assign accept = req && !bad;

  mul_operand_prep #(.XLEN(XLEN)) u_prep (
    .op_i(op_i), .word_i(word_i), .a_i(a_i), .b_i(b_i),
    .a_ext_o(a_ext), .b_ext_o(b_ext)
  );

  mul_iter_core #(.XLEN(XLEN)) u_core (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(accept),
    .a_i(a_ext), .b_i(b_ext), .fin_o(fin), .prod_o(prod)
  );

  mul_result_fix #(.XLEN(XLEN)) u_fix (
    .op_i(op_q), .word_i(word_q), .a_i(a_q), .b_i(b_q),
    .prod_i(prod), .res_o(res_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q    <= 1'b0;
      done_q    <= 1'b0;
      illegal_q <= 1'b0;
      word_q    <= 1'b0;
      op_q      <= '0;
      a_q       <= '0;
      b_q       <= '0;
      res_q     <= '0;
    end else begin
      illegal_q <= req && bad;
      done_q    <= fin;
      if (accept) begin
        busy_q <= 1'b1;
        op_q   <= op_i;
        word_q <= word_i;
        a_q    <= a_ext;
        b_q    <= b_ext;
      end else if (done_q) begin
        busy_q <= 1'b0;
      end
      if (fin) res_q <= res_d;
    end
  end

  assign busy_o    = busy_q;
  assign done_o    = done_q;
  assign illegal_o = illegal_q;
  assign result_o  = res_q;

  a_r8_busy_on_accept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !busy_o && !bad) |=> busy_o);
  a_r8_done_inside_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> busy_o);
  a_r9_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  a_r9_done_from_core: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(fin));
  a_r10_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fin |=> $stable(result_o));
  a_r7_reject_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> (!busy_o && !done_o));
  a_r6_word_sext: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && word_q) |-> (result_o[XLEN-1:HALF] == {HALF{result_o[HALF-1]}}));
endmodule

// File: tb/sim_mul_unit.sv
module sim_mul_unit;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  int checks = 0;
  int errors = 0;

  logic        valid = 1'b0, word = 1'b0;
  logic [1:0]  op = '0;
  logic [63:0] a = '0, b = '0;
  logic        busy, done, illegal;
  logic [63:0] result;

  mul_unit #(.XLEN(64)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .op_i(op), .word_i(word),
    .a_i(a), .b_i(b), .busy_o(busy), .done_o(done), .illegal_o(illegal),
    .result_o(result)
  );

  logic        v1 = 1'b0, w1 = 1'b0;
  logic [1:0]  op1 = '0;
  logic [31:0] a1 = '0, b1 = '0;
  logic        busy1, done1, illegal1;
  logic [31:0] result1;

  mul_unit #(.XLEN(32)) u1 (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(v1), .op_i(op1), .word_i(w1),
    .a_i(a1), .b_i(b1), .busy_o(busy1), .done_o(done1), .illegal_o(illegal1),
    .result_o(result1)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] ref_mul(input logic [1:0] o, input logic w,
                                          input logic [63:0] x, input logic [63:0] y);
    logic [127:0] xe, ye, p;
    logic [63:0]  xw, yw, pw;
    if (w) begin
      xw = (o != 2'd3) ? {{32{x[31]}}, x[31:0]} : {32'b0, x[31:0]};
      yw = (o == 2'd1 || o == 2'd0) ? {{32{y[31]}}, y[31:0]} : {32'b0, y[31:0]};
      pw = xw * yw;
      return (o == 2'd0) ? {{32{pw[31]}}, pw[31:0]} : {{32{pw[63]}}, pw[63:32]};
    end
    xe = (o == 2'd1 || o == 2'd2) ? {{64{x[63]}}, x} : {64'b0, x};
    ye = (o == 2'd1) ? {{64{y[63]}}, y} : {64'b0, y};
    p  = xe * ye;
    return (o == 2'd0) ? p[63:0] : p[127:64];
  endfunction

  function automatic string req_of(input logic [1:0] o, input logic w);
    if (w) return (o == 2'd0) ? "R5" : "R6";
    case (o)
      2'd0: return "R1";
      2'd1: return "R2";
      2'd2: return "R4";
      default: return "R3";
    endcase
  endfunction

  task automatic run_op(input logic [1:0] o, input logic w,
                        input logic [63:0] x, input logic [63:0] y);
    logic [63:0] exp, held;
    int n;
    exp = ref_mul(o, w, x, y);
    @(negedge clk);
    valid = 1'b1; op = o; word = w; a = x; b = y;
    @(negedge clk);
    valid = 1'b0;
    n = 1;
    check(busy == 1'b1, "R8 busy after accept", {63'b0, busy}, 64'd1);
    while (!done && n < 200) begin
      if (n == 5) begin
        valid = 1'b1; op = ~o; word = ~w; a = ~x; b = y + 64'd3;
      end else begin
        valid = 1'b0;
      end
      @(negedge clk);
      n++;
    end
    valid = 1'b0;
    check(n == 66, "R9 latency", 64'(n), 64'd66);
    check(result == exp, req_of(o, w), result, exp);
    check(busy == 1'b1, "R8 busy in done cycle", {63'b0, busy}, 64'd1);
    held = result;
    @(negedge clk);
    check(done == 1'b0, "R9 single pulse", {63'b0, done}, 64'd0);
    check(busy == 1'b0, "R8 idle after done", {63'b0, busy}, 64'd0);
    repeat (2) @(negedge clk);
    check(result == held, "R10 hold", result, held);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    logic [63:0] corner [6];
    void'($urandom(32'd20240607));
    corner[0] = 64'h8000_0000_0000_0000;
    corner[1] = '1;
    corner[2] = '0;
    corner[3] = 64'd1;
    corner[4] = 64'h7fff_ffff_ffff_ffff;
    corner[5] = 64'hdead_beef_8000_0001;
    repeat (3) @(negedge clk);
    // R11 reset state
    check(busy == 0 && done == 0 && illegal == 0, "R11 flags", {61'b0, busy, done, illegal}, 64'd0);
    check(result == '0, "R11 result", result, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int oi = 0; oi < 4; oi++)
      for (int wi = 0; wi < 2; wi++)
        for (int i = 0; i < 6; i += 2)
          run_op(2'(oi), wi[0], corner[i], corner[(i + 1 + oi) % 6]);
    run_op(2'd1, 1'b0, corner[0], corner[1]);
    run_op(2'd1, 1'b0, corner[1], corner[1]);
    run_op(2'd2, 1'b0, corner[1], corner[1]);
    run_op(2'd0, 1'b0, corner[1], corner[0]);
    run_op(2'd1, 1'b1, 64'hffff_ffff_8000_0000, 64'h1234_5678_ffff_ffff);
    run_op(2'd2, 1'b1, 64'h0000_0000_8000_0000, 64'hffff_ffff_ffff_ffff);
    run_op(2'd3, 1'b1, 64'h5555_5555_ffff_ffff, 64'haaaa_aaaa_ffff_ffff);

    for (int k = 0; k < 160; k++)
      run_op(2'($urandom), 1'($urandom), {$urandom, $urandom}, {$urandom, $urandom});

    // R7: word request rejected on a 32-bit configuration
    @(negedge clk);
    v1 = 1'b1; w1 = 1'b1; op1 = 2'd1; a1 = 32'd5; b1 = 32'd7;
    @(negedge clk);
    v1 = 1'b0;
    check(illegal1 == 1'b1, "R7 illegal pulse", {63'b0, illegal1}, 64'd1);
    check(busy1 == 1'b0, "R7 not accepted", {63'b0, busy1}, 64'd0);
    @(negedge clk);
    check(illegal1 == 1'b0, "R7 pulse width", {63'b0, illegal1}, 64'd0);
    begin
      bit seen = 0;
      for (int i = 0; i < 40; i++) begin
        if (done1 || busy1) seen = 1;
        @(negedge clk);
      end
      check(!seen, "R7 no completion", {63'b0, seen}, 64'd0);
    end
    // 32-bit configuration still multiplies in full mode (R1, R9)
    v1 = 1'b1; w1 = 1'b0; op1 = 2'd0; a1 = 32'hffff_fffa; b1 = 32'd7;
    @(negedge clk);
    v1 = 1'b0;
    begin
      int n = 1;
      while (!done1 && n < 100) begin
        @(negedge clk);
        n++;
      end
      check(n == 34, "R9 latency xlen32", 64'(n), 64'd34);
      check(result1 == 32'hffff_ffd6, "R1 xlen32", {32'b0, result1}, 64'hffff_ffd6);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule